// File: doc/BRIEF.md
# Operand Bypass Unit for an In-Order Integer Pipeline

This block sits at the head of the execute stage of a five-stage in-order integer pipeline. For each of the two ALU source operands of the instruction in execute, it decides where the operand value comes from. There are three candidates: the value read from the register file during decode, the ALU result held in the execute/memory pipeline register, and the writeback value held in the memory/writeback pipeline register. The block then drives the chosen value to the ALU input through its own three-way multiplexer. With this, a dependent ALU instruction issued directly behind its producer, or one slot further back, sees the new value without a stall.

A source register is bypassed from a later stage when that stage will write a register and its destination number equals the source number. Each operand makes this decision on its own. Register 0 reads as zero in hardware, so a write aimed at it is never bypassed. When both later stages target the same register, the execute/memory value is used, because it is the younger result. A producer three slots ahead needs no bypass: the register file completes its write before its read in the same cycle, so the decode-stage read already returns the new value.

The block holds no state. Both the selects and the operand values are combinational functions of the current pipeline-register contents.

Top module: `operand_bypass`

## Requirements
- R1: When the execute/memory stage has its write enable set and its destination equals an operand's source register, and that register is not 0, the operand select is 2'b10 and the operand equals the execute/memory ALU result.
- R2: When only the memory/writeback stage matches under the same conditions, the select is 2'b01 and the operand equals the memory/writeback value.
- R3: When both stages match the same nonzero source register, the select is 2'b10 and the execute/memory result is used.
- R4: A source register of 0 is never bypassed. The select is 2'b00 and the operand is the register-file value, even if a stage has write enable set with destination 0.
- R5: A stage whose write enable is clear is never a bypass source, whatever its destination.
- R6: With no match in either stage, the select is 2'b00 and the operand equals the register-file value.
- R7: The two operands are resolved independently. In the same cycle, one operand may take the execute/memory result while the other takes the memory/writeback value or the register file.
- R8: The selects and operands are combinational. They follow an input change without any clock edge, and the select code 2'b11 is never produced.
- R9: In back-to-back ALU sequences with a producer 1, 2 or 3 slots ahead on either operand, every ALU input equals the value a sequential execution would read. This assumes a register file that writes before it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_i | input | REG_AW | First source register number of the instruction in execute |
| ex_rs2_i | input | REG_AW | Second source register number of the instruction in execute |
| rf_rs1_data_i | input | XLEN | Register-file value read for the first source |
| rf_rs2_data_i | input | XLEN | Register-file value read for the second source |
| exmem_wen_i | input | 1 | Execute/memory stage writes a register |
| exmem_rd_i | input | REG_AW | Execute/memory destination register |
| exmem_res_i | input | XLEN | ALU result held in execute/memory |
| memwb_wen_i | input | 1 | Memory/writeback stage writes a register |
| memwb_rd_i | input | REG_AW | Memory/writeback destination register |
| memwb_data_i | input | XLEN | Writeback value held in memory/writeback |
| alu_a_o | output | XLEN | First ALU operand |
| alu_b_o | output | XLEN | Second ALU operand |
| sel_a_o | output | 2 | Source of first operand: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b_o | output | 2 | Source of second operand, same encoding |

## Verification
The block holds no state, so a fault in the compare or priority logic shows up at the ports in the same cycle as the stimulus that exposes it. It appears as a wrong select code and an ALU operand holding a stale or wrong value. In the pipelined sequences a wrong operand also corrupts the producer's result. A later dependent instruction then reads that result, so one bad bypass decision spreads into miscompares on later operands within one to three cycles. Zero-register and write-enable faults are driven with a stage destination that matches the source but must not be taken. The register-file value is distinct from both stage values, so any wrong pick is visible.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int unsigned N_OPND = 2;

  typedef enum logic [1:0] {
    BYP_RF  = 2'b00,
    BYP_WB  = 2'b01,
    BYP_MEM = 2'b10
  } byp_src_e;
endpackage

// File: rtl/byp_match.sv
module byp_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              wen_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic [REG_AW-1:0] rs_i,
  output logic              hit_o
);
  logic rd_nonzero;
  assign rd_nonzero = |rd_i;
  assign hit_o      = wen_i && rd_nonzero && (rd_i == rs_i);
endmodule

// File: rtl/byp_sel.sv
module byp_sel
  import byp_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs_i,
  input  logic              mem_wen_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              wb_wen_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  output byp_src_e          sel_o
);
  logic hit_mem, hit_wb;

  byp_match #(.REG_AW(REG_AW)) u_match_mem (
    .wen_i(mem_wen_i), .rd_i(mem_rd_i), .rs_i(rs_i), .hit_o(hit_mem)
  );
  byp_match #(.REG_AW(REG_AW)) u_match_wb (
    .wen_i(wb_wen_i), .rd_i(wb_rd_i), .rs_i(rs_i), .hit_o(hit_wb)
  );

  // younger result wins
  always_comb begin
    sel_o = BYP_RF;
    if (hit_mem)     sel_o = BYP_MEM;
    else if (hit_wb) sel_o = BYP_WB;
  end
endmodule

// File: rtl/byp_mux.sv
module byp_mux
  import byp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  byp_src_e          sel_i,
  input  logic [XLEN-1:0]   rf_i,
  input  logic [XLEN-1:0]   mem_i,
  input  logic [XLEN-1:0]   wb_i,
  output logic [XLEN-1:0]   opnd_o
);
  always_comb begin
    unique case (sel_i)
      BYP_MEM: opnd_o = mem_i;
      BYP_WB:  opnd_o = wb_i;
      default: opnd_o = rf_i;
    endcase
  end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
  import byp_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [XLEN-1:0]   rf_rs1_data_i,
  input  logic [XLEN-1:0]   rf_rs2_data_i,
  input  logic              exmem_wen_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic [XLEN-1:0]   exmem_res_i,
  input  logic              memwb_wen_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic [XLEN-1:0]   memwb_data_i,
  output logic [XLEN-1:0]   alu_a_o,
  output logic [XLEN-1:0]   alu_b_o,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o
);
  logic [REG_AW-1:0] rs    [N_OPND];
  logic [XLEN-1:0]   rf_d  [N_OPND];
  logic [XLEN-1:0]   opnd  [N_OPND];
  byp_src_e          sel   [N_OPND];

  assign rs[0]   = ex_rs1_i;
  assign rs[1]   = ex_rs2_i;
  assign rf_d[0] = rf_rs1_data_i;
  assign rf_d[1] = rf_rs2_data_i;

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    byp_sel #(.REG_AW(REG_AW)) u_sel (
      .rs_i      (rs[k]),
      .mem_wen_i (exmem_wen_i),
      .mem_rd_i  (exmem_rd_i),
      .wb_wen_i  (memwb_wen_i),
      .wb_rd_i   (memwb_rd_i),
      .sel_o     (sel[k])
    );
    byp_mux #(.XLEN(XLEN)) u_mux (
      .sel_i  (sel[k]),
      .rf_i   (rf_d[k]),
      .mem_i  (exmem_res_i),
      .wb_i   (memwb_data_i),
      .opnd_o (opnd[k])
    );
  end

  assign alu_a_o = opnd[0];
  assign alu_b_o = opnd[1];
  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs1_i,
  input logic [REG_AW-1:0] ex_rs2_i,
  input logic [XLEN-1:0]   rf_rs1_data_i,
  input logic [XLEN-1:0]   rf_rs2_data_i,
  input logic              exmem_wen_i,
  input logic [REG_AW-1:0] exmem_rd_i,
  input logic [XLEN-1:0]   exmem_res_i,
  input logic              memwb_wen_i,
  input logic [REG_AW-1:0] memwb_rd_i,
  input logic [XLEN-1:0]   memwb_data_i,
  input logic [XLEN-1:0]   alu_a_o,
  input logic [XLEN-1:0]   alu_b_o,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o
);
  logic [REG_AW-1:0] c_rs  [2];
  logic [XLEN-1:0]   c_rf  [2];
  logic [XLEN-1:0]   c_op  [2];
  logic [1:0]        c_sel [2];

  assign c_rs[0]  = ex_rs1_i;       assign c_rs[1]  = ex_rs2_i;
  assign c_rf[0]  = rf_rs1_data_i;  assign c_rf[1]  = rf_rs2_data_i;
  assign c_op[0]  = alu_a_o;        assign c_op[1]  = alu_b_o;
  assign c_sel[0] = sel_a_o;        assign c_sel[1] = sel_b_o;

  for (genvar k = 0; k < 2; k++) begin : g_chk
    always_comb begin
      if (c_sel[k] == 2'b10) begin
        a_r1_mem_path: assert (c_op[k] == exmem_res_i && exmem_wen_i &&
                               exmem_rd_i == c_rs[k] && c_rs[k] != '0);
      end
      if (c_sel[k] == 2'b01) begin
        a_r2_wb_path: assert (c_op[k] == memwb_data_i && memwb_wen_i &&
                              memwb_rd_i == c_rs[k] && c_rs[k] != '0);
        a_r3_mem_priority: assert (!(exmem_wen_i && exmem_rd_i == c_rs[k]));
      end
      if (c_sel[k] == 2'b00) begin
        a_r6_rf_path: assert (c_op[k] == c_rf[k]);
      end
      if (c_rs[k] == '0) begin
        a_r4_zero_reg: assert (c_sel[k] == 2'b00);
      end
      if (!exmem_wen_i && !memwb_wen_i) begin
        a_r5_no_write: assert (c_sel[k] == 2'b00);
      end
      a_r8_legal_code: assert (c_sel[k] != 2'b11);
    end
  end
endmodule

bind operand_bypass operand_bypass_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .ex_rs1_i(ex_rs1_i), .ex_rs2_i(ex_rs2_i),
  .rf_rs1_data_i(rf_rs1_data_i), .rf_rs2_data_i(rf_rs2_data_i),
  .exmem_wen_i(exmem_wen_i), .exmem_rd_i(exmem_rd_i), .exmem_res_i(exmem_res_i),
  .memwb_wen_i(memwb_wen_i), .memwb_rd_i(memwb_rd_i), .memwb_data_i(memwb_data_i),
  .alu_a_o(alu_a_o), .alu_b_o(alu_b_o), .sel_a_o(sel_a_o), .sel_b_o(sel_b_o)
);

// File: tb/operand_bypass_tb.sv
`timescale 1ns/1ps
module operand_bypass_tb;
  localparam int XLEN = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0]   ex_rs1, ex_rs2, exmem_rd, memwb_rd;
  logic [XLEN-1:0] rf_a, rf_b, exmem_res, memwb_data;
  logic            exmem_wen, memwb_wen;
  logic [XLEN-1:0] alu_a, alu_b;
  logic [1:0]      sel_a, sel_b;

  operand_bypass #(.XLEN(XLEN), .REG_AW(AW)) u_dut (
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .rf_rs1_data_i(rf_a), .rf_rs2_data_i(rf_b),
    .exmem_wen_i(exmem_wen), .exmem_rd_i(exmem_rd), .exmem_res_i(exmem_res),
    .memwb_wen_i(memwb_wen), .memwb_rd_i(memwb_rd), .memwb_data_i(memwb_data),
    .alu_a_o(alu_a), .alu_b_o(alu_b), .sel_a_o(sel_a), .sel_b_o(sel_b)
  );

  int n_vec = 0;
  int n_err = 0;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  localparam logic [XLEN-1:0] V_RFA = 32'hA0A0_0001;
  localparam logic [XLEN-1:0] V_RFB = 32'hB0B0_0002;
  localparam logic [XLEN-1:0] V_MEM = 32'hC0C0_0003;
  localparam logic [XLEN-1:0] V_WB  = 32'hD0D0_0004;

  task automatic drive(input logic [AW-1:0] rs1, input logic [AW-1:0] rs2,
                       input logic mw, input logic [AW-1:0] mrd,
                       input logic ww, input logic [AW-1:0] wrd);
    @(posedge clk); #1;
    ex_rs1 = rs1; ex_rs2 = rs2; rf_a = V_RFA; rf_b = V_RFB;
    exmem_wen = mw; exmem_rd = mrd; exmem_res = V_MEM;
    memwb_wen = ww; memwb_rd = wrd; memwb_data = V_WB;
    @(negedge clk);
  endtask

  task automatic t_idle;  // R5 R6
    drive(5'd3, 5'd4, 1'b0, 5'd3, 1'b0, 5'd4);
    chk("R5 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R5 alu_a", alu_a, V_RFA);
    chk("R5 alu_b", alu_b, V_RFB);
    drive(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8);
    chk("R6 sel_b", {30'd0, sel_b}, 32'd0);
    chk("R6 alu_a", alu_a, V_RFA);
  endtask

  task automatic t_mem_only;  // R1
    drive(5'd9, 5'd1, 1'b1, 5'd9, 1'b0, 5'd9);
    chk("R1 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R1 alu_a", alu_a, V_MEM);
    chk("R1 alu_b", alu_b, V_RFB);
  endtask

  task automatic t_wb_only;  // R2
    drive(5'd1, 5'd12, 1'b1, 5'd13, 1'b1, 5'd12);
    chk("R2 sel_b", {30'd0, sel_b}, 32'd1);
    chk("R2 alu_b", alu_b, V_WB);
    chk("R2 alu_a", alu_a, V_RFA);
  endtask

  task automatic t_both;  // R3
    drive(5'd6, 5'd6, 1'b1, 5'd6, 1'b1, 5'd6);
    chk("R3 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R3 alu_a", alu_a, V_MEM);
    chk("R3 alu_b", alu_b, V_MEM);
  endtask

  task automatic t_zero;  // R4
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    chk("R4 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R4 alu_a", alu_a, V_RFA);
    chk("R4 alu_b", alu_b, V_RFB);
  endtask

  task automatic t_split;  // R7
    drive(5'd20, 5'd21, 1'b1, 5'd20, 1'b1, 5'd21);
    chk("R7 alu_a", alu_a, V_MEM);
    chk("R7 alu_b", alu_b, V_WB);
    chk("R7 sel_b", {30'd0, sel_b}, 32'd1);
  endtask

  task automatic t_comb;  // R8
    drive(5'd15, 5'd2, 1'b0, 5'd15, 1'b0, 5'd0);
    chk("R8 before", alu_a, V_RFA);
    #0.5 exmem_wen = 1'b1;
    #0.5;
    chk("R8 no-edge alu_a", alu_a, V_MEM);
    chk("R8 no-edge sel_a", {30'd0, sel_a}, 32'd2);
  endtask

  // sequential pipeline harness for R9
  logic [AW-1:0] p_rd [16];
  logic [AW-1:0] p_rs1 [16];
  logic [AW-1:0] p_rs2 [16];

  task automatic ins(input int i, input int rd, input int rs1, input int rs2);
    p_rd[i] = AW'(rd); p_rs1[i] = AW'(rs1); p_rs2[i] = AW'(rs2);
  endtask

  function automatic logic [XLEN-1:0] alu_f(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input int i);
    return (a + b) ^ XLEN'(i * 32'h0101);
  endfunction

  task automatic run_prog(input int n, input string tag);
    logic [XLEN-1:0] rf [32];
    logic [XLEN-1:0] arch [32];
    logic [XLEN-1:0] ea [16];
    logic [XLEN-1:0] eb [16];
    logic ex_v, mem_v, wb_v;
    int ex_i, nxt;
    logic [AW-1:0] ex_r1, ex_r2, ex_rd, mem_rd, wb_rd;
    logic [XLEN-1:0] ex_fa, ex_fb, ex_res, mem_res, wb_dat, na, nb;
    for (int r = 0; r < 32; r++) begin
      rf[r]   = (r == 0) ? '0 : XLEN'(32'h1000 * r + 7);
      arch[r] = rf[r];
    end
    for (int i = 0; i < n; i++) begin
      ea[i] = arch[p_rs1[i]];
      eb[i] = arch[p_rs2[i]];
      if (p_rd[i] != 0) arch[p_rd[i]] = alu_f(ea[i], eb[i], i);
    end
    ex_v = 0; mem_v = 0; wb_v = 0; nxt = 0; ex_i = 0;
    ex_r1 = '0; ex_r2 = '0; ex_rd = '0; mem_rd = '0; wb_rd = '0;
    ex_fa = '0; ex_fb = '0; ex_res = '0; mem_res = '0; wb_dat = '0;
    for (int cyc = 0; cyc < n + 3; cyc++) begin
      @(posedge clk); #1;
      na = '0; nb = '0;
      if (nxt < n) begin  // decode read, write-first register file
        na = (wb_v && wb_rd != 0 && wb_rd == p_rs1[nxt]) ? wb_dat : rf[p_rs1[nxt]];
        nb = (wb_v && wb_rd != 0 && wb_rd == p_rs2[nxt]) ? wb_dat : rf[p_rs2[nxt]];
      end
      if (wb_v && wb_rd != 0) rf[wb_rd] = wb_dat;
      wb_v = mem_v; wb_rd = mem_rd; wb_dat = mem_res;
      mem_v = ex_v; mem_rd = ex_rd; mem_res = ex_res;
      ex_v = (nxt < n);
      if (ex_v) begin
        ex_i = nxt; ex_r1 = p_rs1[nxt]; ex_r2 = p_rs2[nxt]; ex_rd = p_rd[nxt];
        ex_fa = na; ex_fb = nb; nxt++;
      end
      ex_rs1 = ex_r1; ex_rs2 = ex_r2; rf_a = ex_fa; rf_b = ex_fb;
      exmem_wen = mem_v; exmem_rd = mem_rd; exmem_res = mem_res;
      memwb_wen = wb_v; memwb_rd = wb_rd; memwb_data = wb_dat;
      @(negedge clk);
      if (ex_v) begin
        chk({tag, " R9 alu_a"}, alu_a, ea[ex_i]);
        chk({tag, " R9 alu_b"}, alu_b, eb[ex_i]);
        ex_res = alu_f(alu_a, alu_b, ex_i);
      end
    end
  endtask

  task automatic t_seq_d1;  // R9 distance 1
    ins(0, 5, 1, 2); ins(1, 6, 5, 5); ins(2, 7, 6, 1); ins(3, 8, 2, 7);
    run_prog(4, "d1");
  endtask

  task automatic t_seq_d2;  // R9 distance 2
    ins(0, 5, 1, 2); ins(1, 9, 3, 4); ins(2, 6, 1, 5); ins(3, 10, 9, 2); ins(4, 11, 6, 10);
    run_prog(5, "d2");
  endtask

  task automatic t_seq_d3;  // R9 distance 3
    ins(0, 5, 1, 2); ins(1, 9, 3, 4); ins(2, 10, 4, 4); ins(3, 6, 5, 5); ins(4, 11, 1, 9);
    run_prog(5, "d3");
  endtask

  task automatic t_seq_mix;  // R9 with R3 and R4 hazards in flight
    ins(0, 5, 1, 2); ins(1, 5, 5, 3); ins(2, 6, 5, 5); ins(3, 0, 6, 2);
    ins(4, 7, 0, 0); ins(5, 8, 0, 6);
    run_prog(6, "mix");
  endtask

  initial begin
    ex_rs1 = '0; ex_rs2 = '0; rf_a = '0; rf_b = '0;
    exmem_wen = 1'b0; exmem_rd = '0; exmem_res = '0;
    memwb_wen = 1'b0; memwb_rd = '0; memwb_data = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 idle alu_a", alu_a, '0);
    chk("R5 idle sel_a", {30'd0, sel_a}, 32'd0);
    t_idle();
    t_mem_only();
    t_wb_only();
    t_both();
    t_zero();
    t_split();
    t_comb();
    t_seq_d1();
    t_seq_d2();
    t_seq_d3();
    t_seq_mix();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule